// File: doc/BRIEF.md
# Paged GPIO Port Register File

This block is the host-facing register file of a 48-line general-purpose I/O peripheral. A synchronous byte bus reaches six port registers, a read-only interrupt-pending summary, a control register and a three-address window. Each port register holds an output latch. A 1 in a latch bit pulls the matching pin low through an open-drain driver, and a 0 releases the pin so the line can serve as an input. Reading a port register returns the pin levels after a configurable synchronizer.

The control register does two jobs. Its top two bits pick a page, and its low six bits lock the port registers one by one against writes. Pages 1, 2 and 3 place the polarity bank, the enable bank or the interrupt-identity bank of the separate interrupt-capture block into the window at offsets 8 to 10. Each address in the window serves one interrupt-capable port: port 0, 1 or 2. This block only decodes and forwards these accesses. With page 0 the window is dead. A host normally writes 0x40, 0x80 or 0xC0 to select a bank, and each of those values also clears every lock.

Top module: `paged_gpio_regs`

## Requirements
- R1: After reset the page is 0, all lock bits are 0 and all output latches are 0. Every pull-low output is then released, and a read of offset 7 returns 0x00.
- R2: A write to offset p (0..5) whose lock bit p is 0 loads the latch of port p. From the next cycle, pin_pull_low[8p+7:8p] equals the written byte.
- R3: A read of offset p (0..5) returns the level of pins 8p+7..8p. The read sees each pin as it was two clock edges before the edge that captures the read. The data appears on bus_rdata after that edge and holds until the next read.
- R4: While bit p of the lock field is 1, a write to offset p leaves port p's latch unchanged. Writes to other ports are still accepted.
- R5: Offset 7 holds the page in bits 7..6 and the lock field in bits 5..0, one lock bit per port with bit p for port p. A write stores both fields, and a read returns them.
- R6: A read of offset 6 returns the three interrupt-pending inputs in bits 2..0, with bit k for port k, and returns zero in bits 7..3.
- R7: With the page nonzero, a bus write to offset 8+k (k = 0..2) raises ic_wr in that same cycle. In that cycle ic_page equals the page, ic_port equals k and ic_wdata equals the written byte.
- R8: With the page nonzero, a read of offset 8+k raises ic_rd with ic_page and ic_port as in R7. It returns the ic_rdata value present in that cycle.
- R9: With page 0, accesses to offsets 8..10 raise neither ic_wr nor ic_rd, and reads of those offsets return 0x00.
- R10: Offsets 11..15 read as 0x00, and writes to them change no latch and no control state.
- R11: Writing 0x40, 0x80 or 0xC0 to offset 7 selects page 1, 2 or 3 and clears every lock, so a port locked just before accepts the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 48 | Pin levels, line 8p+b is port p bit b |
| pin_pull_low | output | 48 | Open-drain pull-low enables, one per line |
| ic_pending | input | 3 | Pending summary from the interrupt-capture block |
| ic_wr | output | 1 | Write strobe forwarded to the interrupt-capture block |
| ic_rd | output | 1 | Read strobe forwarded to the interrupt-capture block |
| ic_page | output | 2 | Selected bank: 1 polarity, 2 enable, 3 identity |
| ic_port | output | 2 | Interrupt-capable port addressed in the window |
| ic_wdata | output | 8 | Forwarded write data |
| ic_rdata | input | 8 | Bank read data from the interrupt-capture block |

## Verification
The hardest state to reach is a locked port. Reaching it takes a control write that locks the port. Then a port write must be shown to vanish, while a write to a neighbouring port must still land. Last, a bank-select value must remove the lock again. The bench walks that sequence and judges each step on pin_pull_low. It also reads a port right after a pin changes and again one cycle later, which exposes the synchronizer depth. A stand-in interrupt block answers from ic_page and ic_port, so every window read shows whether the right bank and port were forwarded.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
   localparam int PAGE_W = 2;

   typedef enum logic [PAGE_W-1:0] {
      PAGE_OFF = 2'd0,
      PAGE_POL = 2'd1,
      PAGE_ENA = 2'd2,
      PAGE_IDS = 2'd3
   } page_e;
endpackage

// File: rtl/pgpio_addr_decode.sv
module pgpio_addr_decode #(
   parameter int ADDR_W        = 4,
   parameter int NUM_PORTS     = 6,
   parameter int NUM_IRQ_PORTS = 3,
   parameter int IRQ_IDX_W     = 2
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_PORTS-1:0] port_hit,
   output logic                 pend_hit,
   output logic                 ctrl_hit,
   output logic                 bank_hit,
   output logic [IRQ_IDX_W-1:0] bank_idx
);
   localparam int PEND_OFS = NUM_PORTS;
   localparam int CTRL_OFS = NUM_PORTS + 1;
   localparam int BANK_OFS = NUM_PORTS + 2;
   localparam int BANK_END = BANK_OFS + NUM_IRQ_PORTS;

   logic [31:0] addr_ext;
   assign addr_ext = 32'(addr);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_dec
      assign port_hit[p] = (addr_ext == 32'(p));
   end

   assign pend_hit = (addr_ext == 32'(PEND_OFS));
   assign ctrl_hit = (addr_ext == 32'(CTRL_OFS));
   assign bank_hit = (addr_ext >= 32'(BANK_OFS)) && (addr_ext < 32'(BANK_END));
   assign bank_idx = IRQ_IDX_W'(addr_ext - 32'(BANK_OFS));
endmodule

// File: rtl/pgpio_port_slice.sv
module pgpio_port_slice #(
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PORT_W-1:0] wdata,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] latch_q,
   output logic [PORT_W-1:0] pin_lvl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (wr_en) begin
         latch_q <= wdata;
      end
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign pin_lvl = pin_in;
   end else begin : g_sync
      logic [PORT_W-1:0] stage_q [SYNC_STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) begin
               stage_q[s] <= '0;
            end
         end else begin
            stage_q[0] <= pin_in;
            for (int s = 1; s < SYNC_STAGES; s++) begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end

      assign pin_lvl = stage_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/pgpio_page_ctrl.sv
module pgpio_page_ctrl
   import pgpio_pkg::*;
#(
   parameter int NUM_PORTS = 6,
   parameter int PORT_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [PORT_W-1:0]    wdata,
   output page_e                page_q,
   output logic [NUM_PORTS-1:0] lock_q,
   output logic [PORT_W-1:0]    ctrl_rd
);
   localparam int PAGE_LSB = PORT_W - PAGE_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= PAGE_OFF;
         lock_q <= '0;
      end else if (wr_en) begin
         page_q <= page_e'(wdata[PAGE_LSB +: PAGE_W]);
         lock_q <= wdata[NUM_PORTS-1:0];
      end
   end

   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[PAGE_LSB +: PAGE_W] = page_q;
      ctrl_rd[NUM_PORTS-1:0]      = lock_q;
   end
endmodule

// File: rtl/pgpio_bank_route.sv
module pgpio_bank_route
   import pgpio_pkg::*;
#(
   parameter int PORT_W    = 8,
   parameter int IRQ_IDX_W = 2
) (
   input  logic                 bank_hit,
   input  logic                 wr,
   input  logic                 rd,
   input  page_e                page,
   input  logic [IRQ_IDX_W-1:0] bank_idx,
   input  logic [PORT_W-1:0]    wdata,
   output logic                 fwd_wr,
   output logic                 fwd_rd,
   output logic [PAGE_W-1:0]    fwd_page,
   output logic [IRQ_IDX_W-1:0] fwd_port,
   output logic [PORT_W-1:0]    fwd_wdata
);
   logic window_live;

   assign window_live = bank_hit && (page != PAGE_OFF);
   assign fwd_wr      = wr && window_live;
   assign fwd_rd      = rd && window_live;
   assign fwd_page    = page;
   assign fwd_port    = bank_idx;
   assign fwd_wdata   = wdata;
endmodule

// File: rtl/paged_gpio_regs.sv
module paged_gpio_regs
   import pgpio_pkg::*;
#(
   parameter int NUM_PORTS     = 6,
   parameter int PORT_W        = 8,
   parameter int NUM_IRQ_PORTS = 3,
   parameter int ADDR_W        = 4,
   parameter int SYNC_STAGES   = 2,
   localparam int LINES        = NUM_PORTS * PORT_W,
   localparam int IRQ_IDX_W    = (NUM_IRQ_PORTS > 1) ? $clog2(NUM_IRQ_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [PORT_W-1:0]    bus_wdata,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   output logic [PORT_W-1:0]    bus_rdata,
   input  logic [LINES-1:0]     pin_in,
   output logic [LINES-1:0]     pin_pull_low,
   input  logic [NUM_IRQ_PORTS-1:0] ic_pending,
   output logic                 ic_wr,
   output logic                 ic_rd,
   output logic [PAGE_W-1:0]    ic_page,
   output logic [IRQ_IDX_W-1:0] ic_port,
   output logic [PORT_W-1:0]    ic_wdata,
   input  logic [PORT_W-1:0]    ic_rdata
);
   if (PORT_W < NUM_PORTS + PAGE_W) begin : g_chk_ctrl_width
      $error("control byte too narrow for page plus lock fields");
   end
   if (NUM_IRQ_PORTS < 1 || NUM_IRQ_PORTS > NUM_PORTS || NUM_IRQ_PORTS > PORT_W) begin : g_chk_irq
      $error("interrupt-capable port count out of range");
   end
   if (NUM_PORTS + 2 + NUM_IRQ_PORTS > (1 << ADDR_W)) begin : g_chk_addr
      $error("address width cannot reach the bank window");
   end
   if (SYNC_STAGES < 0) begin : g_chk_sync
      $error("synchronizer depth must not be negative");
   end

   logic [NUM_PORTS-1:0] port_hit;
   logic                 pend_hit;
   logic                 ctrl_hit;
   logic                 bank_hit;
   logic [IRQ_IDX_W-1:0] bank_idx;
   page_e                page_q;
   logic [NUM_PORTS-1:0] lock_q;
   logic [PORT_W-1:0]    ctrl_rd;
   logic [PORT_W-1:0]    pin_lvl [NUM_PORTS];
   logic [PORT_W-1:0]    rd_next;

   pgpio_addr_decode #(
      .ADDR_W        (ADDR_W),
      .NUM_PORTS     (NUM_PORTS),
      .NUM_IRQ_PORTS (NUM_IRQ_PORTS),
      .IRQ_IDX_W     (IRQ_IDX_W)
   ) u_dec (
      .addr     (bus_addr),
      .port_hit (port_hit),
      .pend_hit (pend_hit),
      .ctrl_hit (ctrl_hit),
      .bank_hit (bank_hit),
      .bank_idx (bank_idx)
   );

   pgpio_page_ctrl #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && ctrl_hit),
      .wdata   (bus_wdata),
      .page_q  (page_q),
      .lock_q  (lock_q),
      .ctrl_rd (ctrl_rd)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      pgpio_port_slice #(
         .PORT_W      (PORT_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_wr && port_hit[p] && !lock_q[p]),
         .wdata   (bus_wdata),
         .pin_in  (pin_in[p*PORT_W +: PORT_W]),
         .latch_q (pin_pull_low[p*PORT_W +: PORT_W]),
         .pin_lvl (pin_lvl[p])
      );
   end

   pgpio_bank_route #(
      .PORT_W    (PORT_W),
      .IRQ_IDX_W (IRQ_IDX_W)
   ) u_route (
      .bank_hit  (bank_hit),
      .wr        (bus_wr),
      .rd        (bus_rd),
      .page      (page_q),
      .bank_idx  (bank_idx),
      .wdata     (bus_wdata),
      .fwd_wr    (ic_wr),
      .fwd_rd    (ic_rd),
      .fwd_page  (ic_page),
      .fwd_port  (ic_port),
      .fwd_wdata (ic_wdata)
   );

   always_comb begin
      rd_next = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (port_hit[p]) begin
            rd_next = pin_lvl[p];
         end
      end
      if (pend_hit) begin
         rd_next[NUM_IRQ_PORTS-1:0] = ic_pending;
      end
      if (ctrl_hit) begin
         rd_next = ctrl_rd;
      end
      if (ic_rd) begin
         rd_next = ic_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_next;
      end
   end
endmodule

// File: rtl/pgpio_regs_chk.sv
module pgpio_regs_chk #(
   parameter int NUM_PORTS     = 6,
   parameter int PORT_W        = 8,
   parameter int NUM_IRQ_PORTS = 3,
   parameter int ADDR_W        = 4,
   parameter int IRQ_IDX_W     = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [PORT_W-1:0]        bus_wdata,
   input logic                     bus_wr,
   input logic                     bus_rd,
   input logic [PORT_W-1:0]        bus_rdata,
   input logic [NUM_PORTS*PORT_W-1:0] pin_pull_low,
   input logic [NUM_IRQ_PORTS-1:0] ic_pending,
   input logic                     ic_wr,
   input logic [1:0]               ic_page,
   input logic [IRQ_IDX_W-1:0]     ic_port,
   input logic [NUM_PORTS-1:0]     lock_q
);
   localparam int PEND_OFS = NUM_PORTS;
   localparam int BANK_OFS = NUM_PORTS + 2;

   logic [31:0] a_ext;
   logic        in_window;
   assign a_ext     = 32'(bus_addr);
   assign in_window = (a_ext >= 32'(BANK_OFS)) && (a_ext < 32'(BANK_OFS + NUM_IRQ_PORTS));

   // R1
   reset_release_chk: assert property (@(posedge clk) !rst_n |=> (pin_pull_low == '0));

   // R7
   fwd_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ic_wr |-> (bus_wr && in_window && ic_page != 2'd0
                 && 32'(ic_port) == a_ext - 32'(BANK_OFS)));

   // R9
   dead_window_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && in_window && ic_page == 2'd0) |=> (bus_rdata == '0));

   // R6
   pending_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && a_ext == 32'(PEND_OFS)) |=>
      (bus_rdata[NUM_IRQ_PORTS-1:0] == $past(ic_pending)
       && (bus_rdata >> NUM_IRQ_PORTS) == '0));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
      // R4
      locked_port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && a_ext == 32'(p) && lock_q[p]) |=>
         $stable(pin_pull_low[p*PORT_W +: PORT_W]));

      // R2
      open_port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && a_ext == 32'(p) && !lock_q[p]) |=>
         (pin_pull_low[p*PORT_W +: PORT_W] == $past(bus_wdata)));
   end
endmodule

bind paged_gpio_regs pgpio_regs_chk #(
   .NUM_PORTS     (NUM_PORTS),
   .PORT_W        (PORT_W),
   .NUM_IRQ_PORTS (NUM_IRQ_PORTS),
   .ADDR_W        (ADDR_W),
   .IRQ_IDX_W     (IRQ_IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_rdata    (bus_rdata),
   .pin_pull_low (pin_pull_low),
   .ic_pending   (ic_pending),
   .ic_wr        (ic_wr),
   .ic_page      (ic_page),
   .ic_port      (ic_port),
   .lock_q       (lock_q)
);

// File: tb/paged_gpio_regs_bench.sv
`timescale 1ns/1ps
module paged_gpio_regs_bench;
   localparam int CLK_NS = 10;
   localparam int NVEC   = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic [47:0] pin_in = 48'hA5_3C_0F_F0_81_7E;
   logic [47:0] pin_pull_low;
   logic [2:0]  ic_pending = 3'b101;
   logic        ic_wr;
   logic        ic_rd;
   logic [1:0]  ic_page;
   logic [1:0]  ic_port;
   logic [7:0]  ic_wdata;
   logic [7:0]  ic_rdata;

   int n_run  = 0;
   int n_fail = 0;
   logic [12:0] fwd_seen;

   // stand-in interrupt block: answers with the bank and port it was given
   assign ic_rdata = {ic_page, ic_port, 4'hA};

   always #(CLK_NS/2) clk = ~clk;

   paged_gpio_regs u_paged_gpio_regs (
      .clk (clk), .rst_n (rst_n),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
      .pin_in (pin_in), .pin_pull_low (pin_pull_low),
      .ic_pending (ic_pending), .ic_wr (ic_wr), .ic_rd (ic_rd),
      .ic_page (ic_page), .ic_port (ic_port),
      .ic_wdata (ic_wdata), .ic_rdata (ic_rdata)
   );

   // {is_read, addr, wdata, expected}
   localparam logic [20:0] VEC [NVEC] = '{
      {1'b1, 4'd0,  8'h00, 8'h7E},   // R3
      {1'b1, 4'd3,  8'h00, 8'h0F},   // R3
      {1'b1, 4'd5,  8'h00, 8'hA5},   // R3
      {1'b1, 4'd6,  8'h00, 8'h05},   // R6
      {1'b0, 4'd7,  8'h40, 8'h00},   // R11
      {1'b1, 4'd7,  8'h00, 8'h40},   // R5
      {1'b1, 4'd8,  8'h00, 8'h4A},   // R8
      {1'b1, 4'd10, 8'h00, 8'h6A},   // R8
      {1'b0, 4'd7,  8'hC0, 8'h00},   // R11
      {1'b1, 4'd9,  8'h00, 8'hDA},   // R8
      {1'b0, 4'd7,  8'h80, 8'h00},   // R11
      {1'b1, 4'd10, 8'h00, 8'hAA},   // R8
      {1'b0, 4'd7,  8'h00, 8'h00},
      {1'b1, 4'd9,  8'h00, 8'h00},   // R9
      {1'b1, 4'd12, 8'h00, 8'h00},   // R10
      {1'b0, 4'd7,  8'h2A, 8'h00},
      {1'b1, 4'd7,  8'h00, 8'h2A},   // R5
      {1'b0, 4'd7,  8'h00, 8'h00}
   };

   task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      #1;
      fwd_seen = {ic_wr, ic_page, ic_port, ic_wdata};
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      #(CLK_NS * 100000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      check("R1 pull_low", pin_pull_low, 48'h0);
      bus_read(4'd7, rd);
      check("R1 ctrl", {40'h0, rd}, 48'h0);
      bus_read(4'd8, rd);
      check("R9 reset window", {40'h0, rd}, 48'h0);

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][20]) begin
            bus_read(VEC[i][19:16], rd);
            check($sformatf("R3/R5/R6/R8/R9/R10 vec %0d", i), {40'h0, rd}, {40'h0, VEC[i][7:0]});
         end else begin
            bus_write(VEC[i][19:16], VEC[i][15:8]);
         end
      end

      // R2 latch loads
      bus_write(4'd2, 8'h5A);
      check("R2 port2", pin_pull_low, 48'h0000_005A_0000);
      bus_write(4'd0, 8'h01);
      check("R2 port0", pin_pull_low, 48'h0000_005A_0001);

      // R4 lock port 2 only
      bus_write(4'd7, 8'h04);
      bus_write(4'd2, 8'hFF);
      check("R4 locked", pin_pull_low, 48'h0000_005A_0001);
      bus_write(4'd3, 8'h11);
      check("R4 neighbour", pin_pull_low, 48'h0000_115A_0001);
      bus_write(4'd7, 8'h00);
      bus_write(4'd2, 8'h00);
      check("R4 unlocked", pin_pull_low, 48'h0000_1100_0001);

      // R11 bank select clears locks
      bus_write(4'd7, 8'h3F);
      bus_write(4'd0, 8'h00);
      check("R11 all locked", pin_pull_low, 48'h0000_1100_0001);
      bus_write(4'd7, 8'h80);
      bus_write(4'd0, 8'hF0);
      check("R11 lock cleared", pin_pull_low, 48'h0000_1100_00F0);
      bus_read(4'd7, rd);
      check("R11 ctrl", {40'h0, rd}, 48'h80);

      // R7 forwarding under page 2
      bus_write(4'd9, 8'h33);
      check("R7 forward", {35'h0, fwd_seen}, {35'h0, 1'b1, 2'd2, 2'd1, 8'h33});
      check("R7 latches", pin_pull_low, 48'h0000_1100_00F0);

      // R9 page 0 suppresses forwarding
      bus_write(4'd7, 8'h00);
      bus_write(4'd9, 8'h33);
      check("R9 no forward", {47'h0, fwd_seen[12]}, 48'h0);

      // R10 write outside decoded range
      bus_write(4'd13, 8'hFF);
      check("R10 latches", pin_pull_low, 48'h0000_1100_00F0);
      bus_read(4'd7, rd);
      check("R10 ctrl", {40'h0, rd}, 48'h0);

      // R3 synchronizer depth
      @(negedge clk);
      pin_in[39:32] = 8'h99;
      bus_read(4'd4, rd);
      check("R3 old level", {40'h0, rd}, 48'h3C);
      bus_read(4'd4, rd);
      check("R3 new level", {40'h0, rd}, 48'h99);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule